// File: doc/BRIEF.md
# Host-to-DSP Command and Reply Mailbox

This block passes short messages between a host processor and a DSP over three independent channels. Each channel has a 16-bit command word that the host writes and the DSP reads, and a 16-bit reply word that the DSP writes and the host reads. Each channel also has two handshake flags. The command flag shows whether the DSP has picked up the latest command. The reply flag shows whether a fresh reply is waiting for the host. Both flags use inverted polarity: a flag at 0 means the far side has acted.

The host reaches the block through a synchronous register port. It uses a byte address, a write strobe and a read strobe, and read data is returned in the same cycle. The DSP uses its own port, which carries a channel number, a read strobe, a write strobe and write data. The DSP port always shows the command word of the selected channel. A configuration register holds one interrupt enable per channel. The host interrupt stays high while any enabled channel holds an unread reply.

Reset is asserted asynchronously and active-low, and the block releases it through a two-stage synchronizer. Release therefore takes effect on the second rising clock edge after the reset input goes high.

Top module: `mbx_host_dsp`

## Requirements
- R1: While in reset and after reset, all command words, all reply words and the configuration register read 0, the status register at 0x0C reads 0xFC00 (all six flags at 1), and `irq` is 0.
- R2: Host address map: the command word of channel n is at 0x20+8n and reply n is at 0x24+8n, both read through `h_rdata` in the same cycle. `d_rdata` shows the command word of channel `d_ch` in the same cycle.
- R3: A host write to command n stores the data and sets status bit 13+n to 1 from the next cycle.
- R4: A DSP read of command n (`d_rd` with `d_ch`=n) clears status bit 13+n to 0 from the next cycle.
- R5: If a host write and a DSP read of the same command word fall in the same cycle, the DSP sees the old word in that cycle, the new word is stored, and the command flag ends at 1.
- R6: A DSP write to reply n stores `d_wdata` and clears status bit 10+n to 0 from the next cycle.
- R7: A host read strobe at reply n's address sets status bit 10+n back to 1 from the next cycle. If a DSP write to reply n falls in the same cycle, the host gets the old word, the new word is stored, and the flag ends at 0.
- R8: The configuration register is at 0x08. Bit 9+n is the interrupt enable of channel n. Only bits 11:9 are stored, and all other bits read 0.
- R9: `irq` is 1 exactly when some channel n has enable bit 9+n set and reply flag 10+n at 0. It follows changes of the flags and of the enables from the next cycle.
- R10: Host writes to reply or status addresses or to unmapped addresses change nothing, and unmapped addresses read 0. DSP strobes with `d_ch`=3 change nothing, and `d_rdata` reads 0 for that value.
- R11: Host reads of command words, the status register or the configuration register leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| h_addr | input | 8 | Host byte address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (sets reply flags) |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data for `h_addr`, same cycle |
| d_ch | input | 2 | DSP channel select |
| d_wr | input | 1 | DSP reply write strobe |
| d_rd | input | 1 | DSP command read strobe (clears command flag) |
| d_wdata | input | 16 | DSP reply data |
| d_rdata | output | 16 | Command word of channel `d_ch` |
| irq | output | 1 | Host interrupt, reply waiting on an enabled channel |

## Verification
The bench targets the two same-cycle collisions. In the first, a host command write meets a DSP read of the same channel. In the second, a DSP reply write meets a host reply read. A design that resolved either collision the other way would leave a command that looks consumed but was never seen, or drop a reply flag the host never saw. The bench also checks that status bits sit at the right positions and that interrupt enables mask only their own channel, since a swapped index would raise `irq` for the wrong reply. Finally, it drives stores to reply, status and unmapped addresses, DSP strobes on the nonexistent channel 3, and plain host reads of commands and status, none of which may move any flag or word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int STS_REP_LSB = 10;
  localparam int STS_CMD_LSB = 13;
  localparam int CFG_IE_LSB  = 9;
  localparam int CFG_OFS     = 'h08;
  localparam int STS_OFS     = 'h0C;
  localparam int CH_BASE     = 'h20;
  localparam int CH_STRIDE   = 8;
  localparam int REP_OFS     = 4;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= stg_d;
  end

  assign rst_q = stg_q[1];
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_cmd_we,
  input  logic              h_rep_re,
  input  logic              d_cmd_re,
  input  logic              d_rep_we,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [DATA_W-1:0] d_wdata,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] rep_q,
  output logic              cmd_flag,
  output logic              rep_flag
);
  logic              cmd_en, rep_en, cflag_en, rflag_en;
  logic [DATA_W-1:0] cmd_d, rep_d;
  logic              cflag_d, rflag_d;

  always_comb begin
    cmd_en   = h_cmd_we;
    cmd_d    = h_wdata;
    cflag_en = h_cmd_we | d_cmd_re;
    cflag_d  = h_cmd_we;        // host write wins a collision
    rep_en   = d_rep_we;
    rep_d    = d_wdata;
    rflag_en = d_rep_we | h_rep_re;
    rflag_d  = ~d_rep_we;       // fresh reply wins a collision
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      rep_q    <= '0;
      cmd_flag <= 1'b1;
      rep_flag <= 1'b1;
    end else begin
      if (cmd_en)   cmd_q    <= cmd_d;
      if (rep_en)   rep_q    <= rep_d;
      if (cflag_en) cmd_flag <= cflag_d;
      if (rflag_en) rep_flag <= rflag_d;
    end
  end

  // R3
  cmd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_cmd_we |=> (cmd_flag && cmd_q == $past(h_wdata)));
  // R4
  cmd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_cmd_re && !h_cmd_we) |=> !cmd_flag);
  // R6
  rep_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_rep_we |=> (!rep_flag && rep_q == $past(d_wdata)));
  // R7
  rep_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rep_re && !d_rep_we) |=> rep_flag);
  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_cmd_we && !d_cmd_re && !h_rep_re && !d_rep_we) |=> ($stable(cmd_flag) && $stable(rep_flag)));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int NUM_CH = 3
) (
  input  logic [NUM_CH-1:0] ie,
  input  logic [NUM_CH-1:0] rep_flag,
  output logic              irq
);
  logic [NUM_CH-1:0] pend;

  always_comb begin
    pend = ie & ~rep_flag;
    irq  = |pend;
  end
endmodule

// File: rtl/mbx_host_dsp.sv
module mbx_host_dsp #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 3,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic [CH_W-1:0]   d_ch,
  input  logic              d_wr,
  input  logic              d_rd,
  input  logic [DATA_W-1:0] d_wdata,
  output logic [DATA_W-1:0] d_rdata,
  output logic              irq
);
  import mbx_pkg::*;

  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_OFS);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFS);

  logic              rst_q;
  logic [DATA_W-1:0] cmd_q [NUM_CH];
  logic [DATA_W-1:0] rep_q [NUM_CH];
  logic [NUM_CH-1:0] cmd_flag, rep_flag;
  logic [NUM_CH-1:0] cmd_hit, rep_hit, d_sel;
  logic [NUM_CH-1:0] cfg_ie_q, cfg_ie_d;
  logic              cfg_we, d_ok;

  mbx_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  assign d_ok = ({1'b0, d_ch} < (CH_W+1)'(NUM_CH));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CH_BASE + i*CH_STRIDE);
    localparam logic [ADDR_W-1:0] REP_A = ADDR_W'(CH_BASE + i*CH_STRIDE + REP_OFS);

    assign cmd_hit[i] = (h_addr == CMD_A);
    assign rep_hit[i] = (h_addr == REP_A);
    assign d_sel[i]   = d_ok && (d_ch == CH_W'(i));

    mbx_chan #(.DATA_W(DATA_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_q),
      .h_cmd_we (h_wr & cmd_hit[i]),
      .h_rep_re (h_rd & rep_hit[i]),
      .d_cmd_re (d_rd & d_sel[i]),
      .d_rep_we (d_wr & d_sel[i]),
      .h_wdata  (h_wdata),
      .d_wdata  (d_wdata),
      .cmd_q    (cmd_q[i]),
      .rep_q    (rep_q[i]),
      .cmd_flag (cmd_flag[i]),
      .rep_flag (rep_flag[i])
    );
  end

  // configuration register: next state and register
  always_comb begin
    cfg_we   = h_wr && (h_addr == CFG_A);
    cfg_ie_d = h_wdata[CFG_IE_LSB +: NUM_CH];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      cfg_ie_q <= '0;
    else if (cfg_we) cfg_ie_q <= cfg_ie_d;
  end

  // host read mux
  always_comb begin
    h_rdata = '0;
    if (h_addr == CFG_A) h_rdata[CFG_IE_LSB +: NUM_CH] = cfg_ie_q;
    if (h_addr == STS_A) begin
      h_rdata[STS_REP_LSB +: NUM_CH] = rep_flag;
      h_rdata[STS_CMD_LSB +: NUM_CH] = cmd_flag;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (cmd_hit[i]) h_rdata = cmd_q[i];
      if (rep_hit[i]) h_rdata = rep_q[i];
    end
  end

  // DSP read mux
  always_comb begin
    d_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (d_sel[i]) d_rdata = cmd_q[i];
    end
  end

  mbx_irq #(.NUM_CH(NUM_CH)) u_irq (
    .ie       (cfg_ie_q),
    .rep_flag (rep_flag),
    .irq      (irq)
  );

  // R8
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_q)
    cfg_we |=> (cfg_ie_q == $past(cfg_ie_d)));
  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (d_wr && |(d_sel & cfg_ie_q) && !cfg_we) |=> irq);
  // R10
  bad_ch_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!d_ok && !h_wr && !h_rd) |=> ($stable(cmd_flag) && $stable(rep_flag)));
endmodule

// File: tb/mbx_host_dsp_test.sv
`timescale 1ns/1ps
module mbx_host_dsp_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  h_addr;
  logic        h_wr, h_rd;
  logic [15:0] h_wdata;
  logic [15:0] h_rdata;
  logic [1:0]  d_ch;
  logic        d_wr, d_rd;
  logic [15:0] d_wdata;
  logic [15:0] d_rdata;
  logic        irq;

  always #2 clk = ~clk;

  mbx_host_dsp uut (
    .clk(clk), .rst_n(rst_n),
    .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .d_ch(d_ch), .d_wr(d_wr), .d_rd(d_rd), .d_wdata(d_wdata), .d_rdata(d_rdata),
    .irq(irq)
  );

  int total = 0;
  int bad = 0;
  bit live = 1'b0;
  int m_cmd [3];
  int m_rep [3];
  bit m_cf [3];
  bit m_rf [3];
  int m_cfg;
  logic [15:0] last_hr, last_dr;
  logic        last_irq;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int cmd_ch(int a);
    for (int n = 0; n < 3; n++) if (a == 'h20 + 8*n) return n;
    return -1;
  endfunction

  function automatic int rep_ch(int a);
    for (int n = 0; n < 3; n++) if (a == 'h24 + 8*n) return n;
    return -1;
  endfunction

  function automatic int exp_hrd(int a);
    int v = 0;
    if (a == 'h08) return m_cfg;
    if (a == 'h0C) begin
      for (int n = 0; n < 3; n++) v |= (int'(m_cf[n]) << (13+n)) | (int'(m_rf[n]) << (10+n));
      return v;
    end
    if (cmd_ch(a) >= 0) return m_cmd[cmd_ch(a)];
    if (rep_ch(a) >= 0) return m_rep[rep_ch(a)];
    return 0;
  endfunction

  function automatic string tag_of(int a);
    if (a == 'h08) return "R8";
    if (a == 'h0C) return "R3";
    if (cmd_ch(a) >= 0) return "R2";
    if (rep_ch(a) >= 0) return "R6";
    return "R10";
  endfunction

  function automatic int exp_irq();
    for (int n = 0; n < 3; n++) if (m_cfg[9+n] && !m_rf[n]) return 1;
    return 0;
  endfunction

  task automatic mreset();
    for (int n = 0; n < 3; n++) begin
      m_cmd[n] = 0; m_rep[n] = 0; m_cf[n] = 1; m_rf[n] = 1;
    end
    m_cfg = 0;
  endtask

  task automatic mupd();
    int a = int'(h_addr);
    if (h_wr && a == 'h08) m_cfg = int'(h_wdata) & 'h0E00;
    if (h_rd && rep_ch(a) >= 0) m_rf[rep_ch(a)] = 1;
    if (d_rd && d_ch < 3) m_cf[d_ch] = 0;
    if (d_wr && d_ch < 3) begin m_rep[d_ch] = int'(d_wdata); m_rf[d_ch] = 0; end
    if (h_wr && cmd_ch(a) >= 0) begin m_cmd[cmd_ch(a)] = int'(h_wdata); m_cf[cmd_ch(a)] = 1; end
  endtask

  task automatic clr();
    h_addr = 8'h00; h_wr = 0; h_rd = 0; h_wdata = 16'h0;
    d_ch = 2'd0; d_wr = 0; d_rd = 0; d_wdata = 16'h0;
  endtask

  task automatic cyc();
    @(negedge clk);
    last_hr = h_rdata; last_dr = d_rdata; last_irq = irq;
    if (live) begin
      chk(tag_of(int'(h_addr)), h_rdata, exp_hrd(int'(h_addr)));
      chk("R2", d_rdata, (d_ch < 3) ? m_cmd[d_ch] : 0);
      chk("R9", irq, exp_irq());
    end
    @(posedge clk); #1;
    if (live) mupd();
  endtask

  task automatic hwr(int a, int d);
    clr(); h_addr = 8'(a); h_wr = 1; h_wdata = 16'(d); cyc(); clr();
  endtask
  task automatic hrd(int a);
    clr(); h_addr = 8'(a); h_rd = 1; cyc(); clr();
  endtask
  task automatic drd(int c);
    clr(); d_ch = 2'(c); d_rd = 1; cyc(); clr();
  endtask
  task automatic dwr(int c, int d);
    clr(); d_ch = 2'(c); d_wr = 1; d_wdata = 16'(d); cyc(); clr();
  endtask
  task automatic peek(int c);
    clr(); d_ch = 2'(c); cyc(); clr();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got running expected finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr();
    rst_n = 0;
    mreset();
    repeat (3) @(posedge clk);
    #1;
    // R1 values while reset is held
    h_addr = 8'h0C; cyc(); chk("R1", last_hr, 16'hFC00); chk("R1", last_irq, 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    live = 1;

    // R1 after release
    hrd('h0C); chk("R1", last_hr, 16'hFC00);
    hrd('h08); chk("R1", last_hr, 0);
    hrd('h20); chk("R1", last_hr, 0);
    hrd('h24); chk("R1", last_hr, 0);
    chk("R1", last_irq, 0);

    // R4 then R3 on channel 1
    drd(1); chk("R4", last_dr, 0);
    hrd('h0C); chk("R4", last_hr, 16'hBC00);
    hwr('h28, 'hBEEF);
    hrd('h0C); chk("R3", last_hr, 16'hFC00);
    peek(1); chk("R2", last_dr, 16'hBEEF);
    hrd('h28); chk("R2", last_hr, 16'hBEEF);

    // R5 collision on channel 0
    clr(); h_addr = 8'h20; h_wr = 1; h_wdata = 16'h1234; d_ch = 2'd0; d_rd = 1; cyc(); clr();
    chk("R5", last_dr, 0);
    hrd('h0C); chk("R5", last_hr, 16'hFC00);
    peek(0); chk("R5", last_dr, 16'h1234);
    drd(0);
    hrd('h0C); chk("R4", last_hr, 16'hDC00);
    hwr('h20, 'h1235);

    // R6 / R7 on channel 2 with interrupts off
    dwr(2, 'hA5A5);
    hrd('h0C); chk("R6", last_hr, 16'hEC00); chk("R9", last_irq, 0);
    hrd('h34); chk("R6", last_hr, 16'hA5A5);
    hrd('h0C); chk("R7", last_hr, 16'hFC00);

    // R8 / R9
    hwr('h08, 'hFFFF);
    hrd('h08); chk("R8", last_hr, 16'h0E00); chk("R9", last_irq, 0);
    dwr(0, 'h0001);
    peek(0); chk("R9", last_irq, 1);
    hwr('h08, 'h0400);
    peek(0); chk("R9", last_irq, 0);
    hwr('h08, 'h0200);
    peek(0); chk("R9", last_irq, 1);
    hrd('h24); chk("R6", last_hr, 16'h0001);
    peek(0); chk("R9", last_irq, 0);

    // R7 collision on channel 1
    clr(); h_addr = 8'h2C; h_rd = 1; d_ch = 2'd1; d_wr = 1; d_wdata = 16'h5A5A; cyc(); clr();
    chk("R7", last_hr, 0);
    hrd('h0C); chk("R7", last_hr, 16'hF400);
    hrd('h2C); chk("R7", last_hr, 16'h5A5A);
    hrd('h0C); chk("R7", last_hr, 16'hFC00);

    // R10 ignored accesses
    hwr('h24, 'h7777);
    hwr('h0C, 'h0000);
    hwr('h40, 'hFFFF);
    hrd('h40); chk("R10", last_hr, 0);
    hrd('h24); chk("R10", last_hr, 16'h0001);
    hrd('h20); chk("R10", last_hr, 16'h1235);
    hrd('h30); chk("R10", last_hr, 0);
    peek(3); chk("R10", last_dr, 0);
    drd(3);
    dwr(3, 'hFFFF);
    hrd('h0C); chk("R10", last_hr, 16'hFC00);
    hrd('h34); chk("R10", last_hr, 16'hA5A5);

    // R11 host reads of commands and status leave flags alone
    drd(2);
    dwr(0, 'h0F0F);
    hrd('h30); hrd('h20); hrd('h08);
    hrd('h0C); chk("R11", last_hr, 16'h7800); chk("R11", last_irq, 1);
    hrd('h0C); chk("R11", last_hr, 16'h7800);
    hrd('h24); chk("R7", last_hr, 16'h0F0F);
    hrd('h0C); chk("R11", last_hr, 16'h7C00);

    // mixed traffic against the model
    for (int k = 0; k < 3000; k++) begin
      int pick = int'($urandom_range(0, 8));
      clr();
      case (pick)
        0: h_addr = 8'h08; 1: h_addr = 8'h0C; 2: h_addr = 8'h20;
        3: h_addr = 8'h24; 4: h_addr = 8'h28; 5: h_addr = 8'h2C;
        6: h_addr = 8'h30; 7: h_addr = 8'h34; default: h_addr = 8'h40;
      endcase
      h_wr = ($urandom_range(0, 3) == 0);
      h_rd = ($urandom_range(0, 1) == 0);
      h_wdata = 16'($urandom);
      d_ch = 2'($urandom_range(0, 3));
      d_wr = ($urandom_range(0, 3) == 0);
      d_rd = ($urandom_range(0, 2) == 0);
      d_wdata = 16'($urandom);
      cyc();
    end
    clr();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule